// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit

This purely combinational unit takes a data word and either leaves it as it is, moves it by one bit position left or right, or rotates it right by zero to three positions. A two-bit select picks the movement and a two-bit mode picks how vacated bits are filled: logical fill with zero, arithmetic fill that keeps the sign, or a rotate in which no bit is lost.

Every result bit comes from its own four-way multiplexer. The mode decides which neighbouring input bits are wired onto the four multiplexer legs. A separate detector raises a sign-error flag when an arithmetic left shift would make the result's sign differ from the operand's sign. The default width is 4 bits.

Mode encoding: `00` logical, `01` arithmetic, `10` rotate, `11` reserved. In the shift modes, select `0x` passes the word through, `10` moves it right by one and `11` moves it left by one. In rotate mode the select value is the right-rotate distance.

Top module: `step_shift_rotate`

## Requirements
- R1: In mode 00 or 01 with select 00 or 01, data_out equals data_in and sign_err is 0.
- R2: In mode 00 or 01 with select 11, data_out is data_in moved one place toward the MSB: the old MSB is discarded and bit 0 is 0.
- R3: In mode 00 with select 10, data_out is data_in moved one place toward bit 0, and the MSB is filled with 0.
- R4: In mode 01 with select 10, data_out is data_in moved one place toward bit 0, and the old MSB is copied into the MSB (1100 gives 1110).
- R5: In mode 10, data_out is data_in rotated right by the select value (0 to 3). Bits leaving bit 0 re-enter at the MSB, so 0001 with select 01 gives 1000.
- R6: sign_err is 1 exactly when the mode is 01, the select is 11, and data_in bits 3 and 2 (the top two bits) differ. Otherwise it is 0.
- R7: In mode 11 (reserved), data_out equals data_in for every select value and sign_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 4 | Operand word |
| sel | input | 2 | Movement select / rotate distance |
| mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 reserved |
| data_out | output | 4 | Result word |
| sign_err | output | 1 | Sign changed by an arithmetic left shift |

## Verification
Two functions can act on the same input: the shifted word and the sign-error flag. Both come from an arithmetic left shift, and the flag must appear only when the two top operand bits differ. The bench sweeps every operand under mode 01 with select 11, so the flag is raised on some operands and left low on others. Each item is judged on both outputs together against a model. Rotate and pass-through codes that share select values are compared under the same sweep, to show that the mode alone separates them.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_ARITH = 2'b01,
        MODE_ROT   = 2'b10,
        MODE_RSVD  = 2'b11
    } ssr_mode_e;

    localparam int unsigned SEL_W  = 2;
    localparam int unsigned LEGS   = 1 << SEL_W;
endpackage

// File: rtl/ssr_mux4.sv
module ssr_mux4
    import ssr_pkg::*;
(
    input  logic [LEGS-1:0]  leg,
    input  logic [SEL_W-1:0] code,
    output logic             y
);
    always_comb begin
        case (code)
            2'd0:    y = leg[0];
            2'd1:    y = leg[1];
            2'd2:    y = leg[2];
            default: y = leg[3];
        endcase
    end
endmodule

// File: rtl/ssr_sign_chk.sv
module ssr_sign_chk
    import ssr_pkg::*;
(
    input  ssr_mode_e        mode,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       top_bits,
    output logic             err
);
    logic err_d;

    always_comb begin
        err_d = 1'b0;
        if (mode == MODE_ARITH && sel == 2'b11)
            err_d = top_bits[1] ^ top_bits[0];
    end

    assign err = err_d;

    always_comb begin
        if (err) AST_FLAG_SCOPE: assert (mode == MODE_ARITH && sel == 2'b11); // R6
    end
endmodule

// File: rtl/step_shift_rotate.sv
module step_shift_rotate
    import ssr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [1:0]       sel,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] data_out,
    output logic             sign_err
);
    localparam int unsigned MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
        logic             err;
    } ssr_res_t;

    ssr_mode_e            mode_e;
    logic                 right_fill;
    logic [WIDTH-1:0]     word_d;
    logic                 err_d;
    ssr_res_t             res_d;

    assign mode_e     = ssr_mode_e'(mode);
    assign right_fill = (mode_e == MODE_ARITH) ? data_in[MSB] : 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [LEGS-1:0] leg_shift;
        logic [LEGS-1:0] leg_rot;
        logic [LEGS-1:0] leg_sel;
        logic            right_src;
        logic            left_src;

        if (i == MSB) begin : g_top
            assign right_src = right_fill;
        end else begin : g_mid
            assign right_src = data_in[i+1];
        end

        if (i == 0) begin : g_low
            assign left_src = 1'b0;
        end else begin : g_up
            assign left_src = data_in[i-1];
        end

        assign leg_shift = {left_src, right_src, data_in[i], data_in[i]};

        for (genvar k = 0; k < LEGS; k++) begin : g_rot
            assign leg_rot[k] = data_in[(i + k) % WIDTH];
        end

        always_comb begin
            case (mode_e)
                MODE_LOGIC, MODE_ARITH: leg_sel = leg_shift;
                MODE_ROT:               leg_sel = leg_rot;
                default:                leg_sel = {LEGS{data_in[i]}};
            endcase
        end

        ssr_mux4 u_mux (
            .leg  (leg_sel),
            .code (sel),
            .y    (word_d[i])
        );
    end

    ssr_sign_chk u_chk (
        .mode     (mode_e),
        .sel      (sel),
        .top_bits (data_in[MSB -: 2]),
        .err      (err_d)
    );

    always_comb begin
        res_d.word = word_d;
        res_d.err  = err_d;
    end

    assign data_out = res_d.word;
    assign sign_err = res_d.err;

    always_comb begin
        if ((mode_e == MODE_LOGIC || mode_e == MODE_ARITH) && !sel[1])
            AST_PASS_HOLD: assert (data_out == data_in && !sign_err); // R1
        if ((mode_e == MODE_LOGIC || mode_e == MODE_ARITH) && sel == 2'b11)
            AST_LEFT_ZERO_FILL: assert (data_out[0] == 1'b0); // R2
        if (mode_e == MODE_LOGIC && sel == 2'b10)
            AST_LOGIC_TOP_ZERO: assert (data_out[MSB] == 1'b0); // R3
        if (mode_e == MODE_ARITH && sel == 2'b10)
            AST_ARITH_TOP_SIGN: assert (data_out[MSB] == data_in[MSB]); // R4
        if (mode_e == MODE_ROT)
            AST_ROT_KEEPS_ONES: assert ($countones(data_out) == $countones(data_in)); // R5
        if (mode_e == MODE_RSVD)
            AST_RSVD_PASS: assert (data_out == data_in && !sign_err); // R7
    end
endmodule

// File: tb/step_shift_rotate_tb_top.sv
module step_shift_rotate_tb_top;
    localparam int W = 4;

    typedef struct {
        logic [W-1:0] din;
        logic [1:0]   sel;
        logic [1:0]   mode;
        logic [W-1:0] exp_out;
        logic         exp_err;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] data_in = '0;
    logic [1:0]   sel = '0;
    logic [1:0]   mode = '0;
    logic [W-1:0] data_out;
    logic         sign_err;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    step_shift_rotate #(.WIDTH(W)) dut_i (
        .data_in  (data_in),
        .sel      (sel),
        .mode     (mode),
        .data_out (data_out),
        .sign_err (sign_err)
    );

    function automatic item_t model(logic [W-1:0] a, logic [1:0] s, logic [1:0] m);
        item_t it;
        logic [2*W-1:0] dbl;
        it.din = a; it.sel = s; it.mode = m;
        it.exp_out = a; it.exp_err = 1'b0; it.tag = "R1";
        if (m == 2'b11) begin
            it.tag = "R7";
        end else if (m == 2'b10) begin
            dbl = {a, a} >> s;
            it.exp_out = dbl[W-1:0];
            it.tag = "R5";
        end else if (s == 2'b11) begin
            it.exp_out = a << 1;
            it.exp_err = (m == 2'b01) && (a[W-1] != a[W-2]);
            it.tag = (m == 2'b01) ? "R2/R6" : "R2";
        end else if (s == 2'b10) begin
            if (m == 2'b01) begin
                it.exp_out = W'($signed(a) >>> 1);
                it.tag = "R4";
            end else begin
                it.exp_out = a >> 1;
                it.tag = "R3";
            end
        end
        return it;
    endfunction

    task automatic drive(logic [W-1:0] a, logic [1:0] s, logic [1:0] m, string tg);
        item_t it;
        @(posedge clk);
        data_in = a; sel = s; mode = m;
        it = model(a, s, m);
        if (tg != "") it.tag = tg;
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                n_checks++;
                if (data_out !== it.exp_out || sign_err !== it.exp_err) begin
                    n_fail++;
                    $display("FAIL %s din=%b sel=%b mode=%b actual out=%b err=%b expected out=%b err=%b",
                             it.tag, it.din, it.sel, it.mode, data_out, sign_err,
                             it.exp_out, it.exp_err);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        // reset state: zero operand, logical pass-through (R1)
        drive('0, 2'b00, 2'b00, "R1 reset");
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // directed corners
        drive(4'b1100, 2'b10, 2'b01, "R4 1100->1110");
        drive(4'b1100, 2'b10, 2'b00, "R3 1100->0110");
        drive(4'b1011, 2'b11, 2'b01, "R6 sign flip neg->pos");
        drive(4'b0100, 2'b11, 2'b01, "R6 sign flip pos->neg");
        drive(4'b1101, 2'b11, 2'b01, "R6 no flip");
        drive(4'b1011, 2'b11, 2'b00, "R6 logical never flags");
        drive(4'b0001, 2'b01, 2'b10, "R5 wrap 0001->1000");
        drive(4'b0110, 2'b01, 2'b00, "R1 sel 01 passes");
        drive(4'b1001, 2'b11, 2'b11, "R7 reserved");
        // exhaustive sweep
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 16; a++)
                    drive(W'(a), 2'(s), 2'(m), "");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule